// File: doc/BRIEF.md
# Card write-data transfer sequencer

This block runs the write-data phase of a memory-card command. Software starts a command with a one-cycle pulse. The block raises a request towards the command path and waits for that path to report the end of transmission. It then waits a bounded number of cycles for the card's response. When the response arrives, the block holds until software enables the data phase. Write bytes that software has pushed into an internal transmit FIFO are then shifted out on a single data line, most significant bit first, with no gap between bytes.

The data phase stops under several conditions, and each one sets its own sticky interrupt flag:
- **FIFO runs dry.** The phase pauses whenever the FIFO is empty before the block is complete.
- **Block completes.** The phase ends when the programmed block length has been sent.
- **Multi-block mode.** The phase pauses after every block.

After each block, the block watches the card's busy indication on the data line and flags its release. Software resumes a paused phase by refilling the FIFO and enabling data again. It can also abort at any time, which empties the FIFO and asks for a stop-transmission command. If no block length has been programmed, data flows until the FIFO runs dry or software aborts.

Top module: `card_wr_seq`

## Requirements
- R1: After reset, `cmd_req`, `data_en`, `dat_oe`, `stop_req` and all `flags` are 0.
- R2: A `start_cmd` pulse while idle drives `cmd_req` high until `cmd_done` is seen. `cmd_done` sets flags[0] (command sent) and drops `cmd_req`. A `start_cmd` pulse while not idle is ignored.
- R3: If `rsp_valid` is not seen within TMO_CYC cycles after `cmd_done`, flags[1] (response timeout) is set and the block returns to idle without entering the data phase.
- R4: A `data_en_set` pulse takes effect only in three places: after the response has arrived, in a FIFO-dry pause, or in a block pause once busy has been released. Elsewhere, including idle, it leaves `data_en` at 0.
- R5: While `data_en` is high, FIFO bytes leave in push order, one bit per cycle on `dat_out`, most significant bit first, with `dat_oe` high and no idle cycle between bytes.
- R6: In single-block mode (`multi_blk`=0), a block of `blk_len` bytes that is fully in the FIFO is sent without a pause. The block end then sets flags[2]. Release of `dat_busy` then sets flags[4] and returns the block to idle.
- R7: In multi-block mode, each block end sets flags[2] and clears `data_en`. The next release of `dat_busy` sets flags[4]. The block then waits for `data_en_set` to send the next block.
- R8: If the FIFO is empty at a byte boundary before the block is complete, the phase pauses and sets flags[3]. After a refill and `data_en_set`, the byte count within the block continues where it stopped.
- R9: With `blk_len_vld`=0, no block end ever occurs: flags[2] stays 0 and the transfer ends only by a FIFO-dry pause or an abort.
- R10: A `cmd_off_set` pulse while not idle has the following effects:
  - it returns the block to idle on the next edge, stopping `dat_oe` even in the middle of a byte;
  - it pulses `stop_req` for exactly one cycle;
  - it empties the FIFO.
  While idle, `cmd_off_set` is ignored.
- R11: Flags are sticky, and writing 1 to a bit of `flag_clr` clears only that bit. If a flag is set and cleared in the same cycle, the set wins.
- R12: A push while the FIFO already holds DEPTH bytes is dropped.
- R13: `data_en` is high only while data is being sent, and it drops by itself at every pause or block end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_cmd | input | 1 | Pulse: begin command transmission |
| data_en_set | input | 1 | Pulse: enable or resume data transmission |
| cmd_off_set | input | 1 | Pulse: abort the sequence |
| flag_clr | input | 5 | Write-one-to-clear for each flag |
| multi_blk | input | 1 | 1 = multi-block mode |
| blk_len | input | LEN_W | Block length in bytes |
| blk_len_vld | input | 1 | 1 = a block length has been programmed |
| fifo_push | input | 1 | Push `fifo_din` into the transmit FIFO |
| fifo_din | input | DATA_W | Write byte |
| cmd_done | input | 1 | Command path: transmission finished |
| rsp_valid | input | 1 | Command path: card response received |
| dat_busy | input | 1 | Card holds the data line busy |
| cmd_req | output | 1 | Command transmission requested |
| stop_req | output | 1 | One-cycle request for a stop-transmission command |
| data_en | output | 1 | Data phase active |
| dat_out | output | 1 | Serial write data |
| dat_oe | output | 1 | Data line driven |
| flags | output | 5 | Bit 0 command sent, bit 1 timeout, bit 2 block end, bit 3 FIFO dry, bit 4 busy end |

## Verification
The checker watches several properties on every cycle:
- the data line is only driven while the data phase is enabled;
- the stop request lasts exactly one cycle and leaves every output quiet;
- flags never drop without a matching clear bit;
- a timeout, block end or FIFO-dry event always leaves `data_en` low.

Other behaviour appears only in the bench scenarios, which compare every output against a behavioural model on each clock:
- the exact order and values of the serial bits;
- the continuation of the byte count across a FIFO-dry pause;
- the emptying of the FIFO on abort;
- dropped pushes;
- which pause cause applies for a given block length, FIFO depth and mode.

// File: rtl/cws_pkg.sv
package cws_pkg;
    localparam int NFLAG       = 5;
    localparam int FL_CMD_END  = 0;
    localparam int FL_CMD_TMO  = 1;
    localparam int FL_BLK_END  = 2;
    localparam int FL_FIFO_DRY = 3;
    localparam int FL_BUSY_END = 4;

    typedef enum logic [2:0] {
        S_IDLE, S_CMD, S_RSP, S_RDY, S_SEND, S_PDRY, S_BUSY, S_PBLK
    } seq_st_e;

    typedef struct packed {
        logic pop;
        logic flush;
        logic ser_clr;
        logic stop;
    } seq_act_t;

    function automatic logic may_resume(seq_st_e s);
        return (s == S_RDY) || (s == S_PDRY) || (s == S_PBLK);
    endfunction
endpackage

// File: rtl/cws_fifo.sv
module cws_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    input  logic         flush,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] nxt(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= nxt(wp);
            if (do_pop)  rp <= nxt(rp);
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/cws_ser.sv
module cws_ser #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic         dout,
    output logic         oe,
    output logic         ready
);
    localparam int BW = $clog2(W + 1);

    logic [W-1:0]  sh;
    logic [BW-1:0] left;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh   <= '0;
            left <= '0;
        end else if (clr) begin
            left <= '0;
        end else if (load) begin
            sh   <= din;
            left <= BW'(W);
        end else if (left != '0) begin
            sh   <= sh << 1;
            left <= left - 1'b1;
        end
    end

    assign oe    = (left != '0);
    assign dout  = oe & sh[W-1];
    assign ready = (left <= BW'(1));
endmodule

// File: rtl/cws_ctrl.sv
module cws_ctrl
    import cws_pkg::*;
#(
    parameter int LEN_W   = 10,
    parameter int TMO_CYC = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_cmd,
    input  logic             data_en_set,
    input  logic             cmd_off_set,
    input  logic [NFLAG-1:0] flag_clr,
    input  logic             multi_blk,
    input  logic [LEN_W-1:0] blk_len,
    input  logic             blk_len_vld,
    input  logic             cmd_done,
    input  logic             rsp_valid,
    input  logic             dat_busy,
    input  logic             fifo_empty,
    input  logic             ser_ready,
    output seq_act_t         act,
    output logic             cmd_req,
    output logic             data_en,
    output logic             stop_req,
    output logic [NFLAG-1:0] flags
);
    localparam int TW = $clog2(TMO_CYC + 1);

    seq_st_e          st, st_n;
    logic [LEN_W-1:0] bcnt, bcnt_n;
    logic [TW-1:0]    tcnt, tcnt_n;
    logic [NFLAG-1:0] fset;
    logic             blk_done;

    assign blk_done = blk_len_vld && (bcnt == blk_len);

    always_comb begin
        st_n   = st;
        bcnt_n = bcnt;
        tcnt_n = tcnt;
        fset   = '0;
        act    = '0;
        if (cmd_off_set && st != S_IDLE) begin
            st_n        = S_IDLE;
            act.stop    = 1'b1;
            act.flush   = 1'b1;
            act.ser_clr = 1'b1;
        end else begin
            case (st)
                S_IDLE: if (start_cmd) begin
                    st_n   = S_CMD;
                    bcnt_n = '0;
                end
                S_CMD: if (cmd_done) begin
                    st_n             = S_RSP;
                    tcnt_n           = '0;
                    fset[FL_CMD_END] = 1'b1;
                end
                S_RSP: begin
                    if (rsp_valid) begin
                        st_n = S_RDY;
                    end else if (tcnt == TW'(TMO_CYC - 1)) begin
                        st_n             = S_IDLE;
                        fset[FL_CMD_TMO] = 1'b1;
                    end else begin
                        tcnt_n = tcnt + 1'b1;
                    end
                end
                S_RDY, S_PDRY, S_PBLK: if (data_en_set) st_n = S_SEND;
                S_SEND: if (ser_ready) begin
                    if (blk_done) begin
                        st_n             = S_BUSY;
                        bcnt_n           = '0;
                        fset[FL_BLK_END] = 1'b1;
                    end else if (fifo_empty) begin
                        st_n              = S_PDRY;
                        fset[FL_FIFO_DRY] = 1'b1;
                    end else begin
                        act.pop = 1'b1;
                        bcnt_n  = bcnt + 1'b1;
                    end
                end
                S_BUSY: if (!dat_busy) begin
                    st_n              = multi_blk ? S_PBLK : S_IDLE;
                    fset[FL_BUSY_END] = 1'b1;
                end
                default: st_n = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= S_IDLE;
            bcnt     <= '0;
            tcnt     <= '0;
            flags    <= '0;
            stop_req <= 1'b0;
        end else begin
            st       <= st_n;
            bcnt     <= bcnt_n;
            tcnt     <= tcnt_n;
            flags    <= (flags & ~flag_clr) | fset;
            stop_req <= act.stop;
        end
    end

    assign cmd_req = (st == S_CMD);
    assign data_en = (st == S_SEND);
endmodule

// File: rtl/card_wr_seq.sv
module card_wr_seq
    import cws_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int DEPTH   = 8,
    parameter int LEN_W   = 10,
    parameter int TMO_CYC = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_cmd,
    input  logic              data_en_set,
    input  logic              cmd_off_set,
    input  logic [NFLAG-1:0]  flag_clr,
    input  logic              multi_blk,
    input  logic [LEN_W-1:0]  blk_len,
    input  logic              blk_len_vld,
    input  logic              fifo_push,
    input  logic [DATA_W-1:0] fifo_din,
    input  logic              cmd_done,
    input  logic              rsp_valid,
    input  logic              dat_busy,
    output logic              cmd_req,
    output logic              stop_req,
    output logic              data_en,
    output logic              dat_out,
    output logic              dat_oe,
    output logic [NFLAG-1:0]  flags
);
    seq_act_t          act;
    logic              f_empty, f_full, s_ready;
    logic [DATA_W-1:0] f_dout;

    cws_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .push(fifo_push), .din(fifo_din),
        .pop(act.pop), .flush(act.flush), .dout(f_dout),
        .empty(f_empty), .full(f_full)
    );

    cws_ser #(.W(DATA_W)) u_ser (
        .clk(clk), .rst(rst), .clr(act.ser_clr), .load(act.pop),
        .din(f_dout), .dout(dat_out), .oe(dat_oe), .ready(s_ready)
    );

    cws_ctrl #(.LEN_W(LEN_W), .TMO_CYC(TMO_CYC)) u_ctrl (
        .clk(clk), .rst(rst), .start_cmd(start_cmd), .data_en_set(data_en_set),
        .cmd_off_set(cmd_off_set), .flag_clr(flag_clr), .multi_blk(multi_blk),
        .blk_len(blk_len), .blk_len_vld(blk_len_vld), .cmd_done(cmd_done),
        .rsp_valid(rsp_valid), .dat_busy(dat_busy), .fifo_empty(f_empty),
        .ser_ready(s_ready), .act(act), .cmd_req(cmd_req), .data_en(data_en),
        .stop_req(stop_req), .flags(flags)
    );

    logic unused_full;
    assign unused_full = f_full;
endmodule

// File: rtl/cws_chk.sv
module cws_chk #(
    parameter int NF = 5
) (
    input logic          clk,
    input logic          rst,
    input logic [NF-1:0] flag_clr,
    input logic          cmd_req,
    input logic          stop_req,
    input logic          data_en,
    input logic          dat_oe,
    input logic [NF-1:0] flags
);
    p_oe_needs_en_r5: assert property (@(posedge clk) disable iff (rst)
        dat_oe |-> data_en);

    p_stop_single_r10: assert property (@(posedge clk) disable iff (rst)
        stop_req |=> !stop_req);

    p_stop_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        stop_req |-> (!cmd_req && !data_en && !dat_oe));

    p_flags_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((flags & $past(flags & ~flag_clr)) == $past(flags & ~flag_clr)));

    p_tmo_idle_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(flags[1]) |-> (!cmd_req && !data_en));

    p_cmd_excl_r2: assert property (@(posedge clk) disable iff (rst)
        cmd_req |-> (!data_en && !dat_oe));

    p_blkend_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(flags[2]) |-> (!data_en && !dat_oe));

    p_dry_drops_en_r13: assert property (@(posedge clk) disable iff (rst)
        $rose(flags[3]) |-> !data_en);
endmodule

bind card_wr_seq cws_chk #(.NF(cws_pkg::NFLAG)) u_chk (
    .clk(clk), .rst(rst), .flag_clr(flag_clr), .cmd_req(cmd_req),
    .stop_req(stop_req), .data_en(data_en), .dat_oe(dat_oe), .flags(flags)
);

// File: tb/sim_card_wr_seq.sv
module sim_card_wr_seq;
    localparam int DEPTH = 8;
    localparam int LEN_W = 8;
    localparam int TMO   = 16;

    logic clk = 0, rst = 1;
    logic start_cmd = 0, data_en_set = 0, cmd_off_set = 0;
    logic [4:0] flag_clr = 0;
    logic multi_blk = 0, blk_len_vld = 0;
    logic [LEN_W-1:0] blk_len = 0;
    logic fifo_push = 0;
    logic [7:0] fifo_din = 0;
    logic cmd_done = 0, rsp_valid = 0, dat_busy = 0;
    logic cmd_req, stop_req, data_en, dat_out, dat_oe;
    logic [4:0] flags;

    int nchk = 0, nfail = 0;
    string cur_req = "R1";
    bit finished = 0;

    always #2 clk = ~clk;

    card_wr_seq #(.DATA_W(8), .DEPTH(DEPTH), .LEN_W(LEN_W), .TMO_CYC(TMO)) u0 (
        .clk(clk), .rst(rst), .start_cmd(start_cmd), .data_en_set(data_en_set),
        .cmd_off_set(cmd_off_set), .flag_clr(flag_clr), .multi_blk(multi_blk),
        .blk_len(blk_len), .blk_len_vld(blk_len_vld), .fifo_push(fifo_push),
        .fifo_din(fifo_din), .cmd_done(cmd_done), .rsp_valid(rsp_valid),
        .dat_busy(dat_busy), .cmd_req(cmd_req), .stop_req(stop_req),
        .data_en(data_en), .dat_out(dat_out), .dat_oe(dat_oe), .flags(flags)
    );

    // Behavioural reference: 0 idle,1 command,2 await response,3 ready,
    // 4 sending,5 dry pause,6 busy wait,7 block pause
    int m_st = 0, m_bl = 0, m_cnt = 0, m_tmo = 0;
    logic [7:0] m_sh = 0;
    logic [7:0] m_q[$];
    logic [4:0] m_flags = 0;
    logic m_stop = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_bl = 0; m_cnt = 0; m_tmo = 0; m_sh = 0;
            m_q.delete(); m_flags = 0; m_stop = 0;
        end else begin
            logic [4:0] setf;
            bit pop, flush, clr;
            int presize;
            setf = 0; pop = 0; flush = 0; clr = 0;
            presize = m_q.size();
            m_stop = 0;
            if (cmd_off_set && m_st != 0) begin
                m_st = 0; m_stop = 1; flush = 1; clr = 1;
            end else begin
                case (m_st)
                    0: if (start_cmd) begin m_st = 1; m_cnt = 0; end
                    1: if (cmd_done) begin m_st = 2; m_tmo = 0; setf[0] = 1; end
                    2: if (rsp_valid) m_st = 3;
                       else if (m_tmo == TMO - 1) begin m_st = 0; setf[1] = 1; end
                       else m_tmo++;
                    3, 5, 7: if (data_en_set) m_st = 4;
                    4: if (m_bl <= 1) begin
                        if (blk_len_vld && m_cnt == int'(blk_len)) begin
                            m_st = 6; m_cnt = 0; setf[2] = 1;
                        end else if (presize == 0) begin
                            m_st = 5; setf[3] = 1;
                        end else begin
                            pop = 1; m_cnt = (m_cnt + 1) % 256;
                        end
                    end
                    6: if (!dat_busy) begin m_st = multi_blk ? 7 : 0; setf[4] = 1; end
                    default: m_st = 0;
                endcase
            end
            if (clr) m_bl = 0;
            else if (pop) begin m_sh = m_q[0]; m_bl = 8; end
            else if (m_bl != 0) begin m_sh = m_sh << 1; m_bl--; end
            m_flags = (m_flags & ~flag_clr) | setf;
            if (flush) m_q.delete();
            else begin
                if (pop) void'(m_q.pop_front());
                if (fifo_push && presize < DEPTH) m_q.push_back(fifo_din);
            end
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // per-cycle comparison against the reference model
    always @(negedge clk) begin
        if (!rst && !finished) begin
            logic m_oe;
            m_oe = (m_bl != 0);
            chk(cur_req, {27'd0, cmd_req, stop_req, data_en, dat_oe, dat_out},
                {27'd0, m_st == 1, m_stop, m_st == 4, m_oe, m_oe & m_sh[7]}, "outputs vs model");
            chk(cur_req, {27'd0, flags}, {27'd0, m_flags}, "flags vs model");
        end
    end

    // serial capture
    logic [7:0] got[$];
    logic [7:0] cap_sh = 0;
    int cap_n = 0;
    always @(negedge clk) begin
        if (!rst && dat_oe) begin
            cap_sh = {cap_sh[6:0], dat_out};
            cap_n++;
            if (cap_n == 8) begin got.push_back(cap_sh); cap_n = 0; end
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push_byte(logic [7:0] v);
        @(negedge clk); fifo_push = 1; fifo_din = v;
        @(negedge clk); fifo_push = 0;
    endtask

    task automatic pulse_start();  @(negedge clk); start_cmd = 1;   @(negedge clk); start_cmd = 0;   endtask
    task automatic pulse_done();   @(negedge clk); cmd_done = 1;    @(negedge clk); cmd_done = 0;    endtask
    task automatic pulse_rsp();    @(negedge clk); rsp_valid = 1;   @(negedge clk); rsp_valid = 0;   endtask
    task automatic pulse_den();    @(negedge clk); data_en_set = 1; @(negedge clk); data_en_set = 0; endtask
    task automatic pulse_off();    @(negedge clk); cmd_off_set = 1; @(negedge clk); cmd_off_set = 0; endtask
    task automatic pulse_clr(logic [4:0] m); @(negedge clk); flag_clr = m; @(negedge clk); flag_clr = 0; endtask

    task automatic do_cmd();
        pulse_start(); cyc(2); pulse_done(); cyc(1); pulse_rsp();
    endtask

    task automatic wait_flag(int b, int maxc);
        for (int i = 0; i < maxc; i++) begin
            if (flags[b]) break;
            @(negedge clk);
        end
    endtask

    task automatic reset_cap();
        got.delete(); cap_n = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            nfail++;
            $display("FAIL watchdog expired in %s", cur_req);
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        cyc(3); rst = 0; @(negedge clk);
        cur_req = "R1";
        chk("R1", {cmd_req, data_en, dat_oe, stop_req}, 4'b0, "outputs after reset");
        chk("R1", flags, 5'b0, "flags after reset");

        // R4: enable while idle ignored; R2 command phase; R3 timeout
        cur_req = "R4";
        pulse_den();
        chk("R4", data_en, 0, "data_en after enable in idle");
        cur_req = "R2";
        pulse_start();
        chk("R2", cmd_req, 1, "cmd_req after start");
        pulse_start();
        chk("R2", cmd_req, 1, "second start while busy");
        pulse_done();
        chk("R2", {cmd_req, flags[0]}, 2'b01, "cmd_req/flag0 after cmd_done");
        cur_req = "R3";
        cyc(TMO - 3);
        chk("R3", flags[1], 0, "no early timeout");
        cyc(6);
        chk("R3", {flags[1], cmd_req, data_en}, 3'b100, "timeout flag, idle");
        pulse_den();
        chk("R4", data_en, 0, "enable after timeout ignored");

        cur_req = "R11";
        pulse_clr(5'b00001);
        chk("R11", flags, 5'b00010, "selective clear");
        pulse_clr(5'b11111);
        chk("R11", flags, 5'b0, "clear all");

        // R6 single block within FIFO depth
        cur_req = "R6";
        multi_blk = 0; blk_len_vld = 1; blk_len = 4;
        push_byte(8'hA5); push_byte(8'h3C); push_byte(8'hF0); push_byte(8'h81);
        do_cmd();
        chk("R4", data_en, 0, "data_en before enable");
        dat_busy = 1;
        reset_cap();
        pulse_den();
        chk("R4", data_en, 1, "data_en after enable");
        wait_flag(2, 100);
        chk("R5", got.size(), 4, "bytes sent");
        if (got.size() == 4) begin
            chk("R5", got[0], 8'hA5, "byte0"); chk("R5", got[3], 8'h81, "byte3");
        end
        chk("R6", flags[3], 0, "no dry pause");
        cyc(5);
        chk("R6", flags[4], 0, "busy held");
        dat_busy = 0; cyc(2);
        chk("R6", {flags[4], data_en, cmd_req}, 3'b100, "busy end and idle");
        pulse_clr(5'b11111);

        // R7 multi block
        cur_req = "R7";
        multi_blk = 1; blk_len = 3;
        for (int i = 0; i < 6; i++) push_byte(8'h10 + 8'(i));
        do_cmd();
        reset_cap();
        pulse_den();
        wait_flag(2, 100);
        chk("R13", data_en, 0, "data_en drops at block end");
        chk("R7", got.size(), 3, "first block length");
        cyc(3);
        chk("R7", flags[4], 1, "busy end after block");
        cyc(4);
        chk("R7", {data_en, dat_oe}, 2'b00, "held in block pause");
        pulse_clr(5'b11111);
        pulse_den();
        wait_flag(2, 100);
        chk("R7", got.size(), 6, "second block");
        if (got.size() == 6) chk("R7", got[5], 8'h15, "last byte");
        cur_req = "R10";
        pulse_off();
        chk("R10", stop_req, 1, "stop request");
        cyc(1);
        chk("R10", stop_req, 0, "stop one cycle");
        pulse_clr(5'b11111);

        // R8 / R12 block longer than FIFO
        cur_req = "R8";
        multi_blk = 0; blk_len = 12;
        for (int i = 0; i < 10; i++) push_byte(8'h40 + 8'(i));
        do_cmd();
        reset_cap();
        pulse_den();
        wait_flag(3, 200);
        chk("R8", {flags[3], flags[2], data_en}, 3'b100, "dry pause");
        chk("R12", got.size(), 8, "only DEPTH bytes accepted");
        for (int i = 0; i < 4; i++) push_byte(8'hC0 + 8'(i));
        pulse_den();
        wait_flag(2, 200);
        chk("R8", got.size(), 12, "block completes after resume");
        if (got.size() == 12) begin
            chk("R12", got[8], 8'hC0, "dropped pushes absent");
            chk("R8", got[11], 8'hC3, "final byte");
        end
        cyc(3);
        chk("R8", {cmd_req, data_en}, 2'b00, "idle after block");
        pulse_clr(5'b11111);

        // R9 unbounded
        cur_req = "R9";
        blk_len_vld = 0;
        for (int i = 0; i < 5; i++) push_byte(8'h70 + 8'(i));
        do_cmd();
        reset_cap();
        pulse_den();
        wait_flag(3, 200);
        chk("R9", got.size(), 5, "all bytes sent");
        chk("R9", flags[2], 0, "no block end");

        // R10 abort mid-byte, flush
        cur_req = "R10";
        for (int i = 0; i < 5; i++) push_byte(8'h90 + 8'(i));
        pulse_den();
        cyc(4);
        pulse_off();
        chk("R10", {stop_req, dat_oe, data_en}, 3'b100, "abort mid-byte");
        pulse_clr(5'b11111);
        do_cmd();
        pulse_den();
        cyc(3);
        chk("R10", flags[3], 1, "FIFO emptied by abort");
        pulse_off();
        cyc(2);
        pulse_off();
        chk("R10", stop_req, 0, "abort ignored in idle");
        cyc(3);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule